// File: doc/BRIEF.md
# Host Byte-Port Register Access Unit

This unit is the host-facing slave of a serial test-bus master. A processor reaches it through an asynchronous byte bus made of an active-LOW chip enable, a read/write select, an active-LOW strobe, a 3-bit register address and an 8-bit bidirectional data bus. The host controls are brought into the system clock domain by two-flop synchronizers. One internal access is started for each strobe falling edge seen while chip enable is LOW. The address, direction and write byte are captured at that synchronized edge.

Three addresses are outgoing shift buffers and one is the incoming shift buffer of the scan engine. These connect to the engine through valid/ready streams. A write to an outgoing buffer raises `out_valid` for that channel and holds it, with the byte stable on `out_data`, until the engine asserts the matching `out_ready`. A read of the incoming buffer raises `in_ready` until the engine presents `in_valid`. The engine therefore applies back-pressure through `out_ready` and `in_valid`. The host sees that back-pressure as the active-LOW ready pin, which stays HIGH until the access has completed. Two further addresses hold an interrupt enable mask and a latched event status. The interrupt pin is raised whenever an enabled status bit is set.

Top module: `hbus_reg_port`

## Requirements
- R1: While `host_ce_n` is HIGH, `host_rdy_n` and `host_data` are high-impedance. `host_data` is driven only while `host_ce_n` is LOW, `host_rw` is HIGH (read) and `host_stb_n` is LOW.
- R2: Each synchronized `host_stb_n` falling edge with `host_ce_n` LOW starts exactly one access. Strobe edges while `host_ce_n` is HIGH start none.
- R3: A write (`host_rw` LOW) to address i, where 0 <= i <= 2, produces exactly one transfer on outgoing channel i carrying the written byte. `out_valid[i]` and `out_data` hold steady until `out_ready[i]` is HIGH, and at most one `out_valid` bit is HIGH at a time.
- R4: During an access, `host_rdy_n` stays HIGH until that access completes, however long the engine withholds `out_ready` or `in_valid`. It then goes LOW, and it returns HIGH once the strobe is seen HIGH again.
- R5: A read of address 3 holds `in_ready` HIGH until exactly one `in_valid` transfer occurs, and the host then reads that byte.
- R6: Address 4 is the interrupt enable mask. Its low 4 bits are writable, it reads back with the upper bits zero, and it resets to zero.
- R7: Address 5 is the event status. A HIGH `irq_evt[k]` sets bit k. Writing a 1 to bit k clears it, but an event in the same cycle wins. A read returns the bits with the upper bits zero.
- R8: `host_irq` is HIGH exactly when some status bit is set whose enable bit is also set.
- R9: Addresses 6 and 7 complete with ready asserted. A read returns zero and a write changes no register and no stream.
- R10: After reset, no stream is active, both registers are zero, `host_irq` is LOW and `host_rdy_n` is HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-LOW reset |
| host_ce_n | input | 1 | Chip enable, active LOW |
| host_rw | input | 1 | HIGH read, LOW write |
| host_stb_n | input | 1 | Transfer strobe, active LOW |
| host_addr | input | 3 | Register address |
| host_data | inout | 8 | Host data bus |
| host_rdy_n | output | 1 | Access complete, active LOW; high-impedance while deselected |
| host_irq | output | 1 | Interrupt request, active HIGH |
| out_valid | output | 3 | Outgoing buffer byte valid, one bit per channel |
| out_data | output | 8 | Outgoing buffer byte |
| out_ready | input | 3 | Engine accepts outgoing byte, per channel |
| in_valid | input | 1 | Engine offers an incoming byte |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Unit accepts the incoming byte |
| irq_evt | input | 4 | Interrupt event pulses from the engine |

## Verification
A corrupted sequencer state shows at the ports within a few cycles of the synchronized strobe edge. Possible symptoms are a ready pin that never falls, a second or missing transfer on a stream, or a transfer on the wrong channel. A wrong captured address or byte appears as a mismatch on `out_data` at the moment of transfer, or as a wrong byte on the bus during the read. A damaged enable or status register shows on `host_irq` in the cycle after the event, and on the next read of either address.

// File: rtl/hbus_reg_port_pkg.sv
package hbus_reg_port_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BUSY = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/hbus_irq.sv
module hbus_irq #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             en_we_i,
  input  logic             st_we_i,
  input  logic [EVT_W-1:0] wdata_i,
  output logic [EVT_W-1:0] en_o,
  output logic [EVT_W-1:0] st_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] en_q, st_q, clr_mask;

  assign clr_mask = st_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      st_q <= (st_q & ~clr_mask) | evt_i;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = |(st_q & en_q);

  assert_evt_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_i & en_q)) && !en_we_i) |=> irq_o);
  assert_evt_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[0] |=> st_q[0]);
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_reg_port_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 3,
  parameter int EVT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n_s,
  input  logic               rw_s,
  input  logic               stb_n_s,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_OUT-1:0] out_valid,
  output logic [DATA_W-1:0]  out_data,
  input  logic [NUM_OUT-1:0] out_ready,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  output logic               en_we_o,
  output logic               st_we_o,
  output logic [EVT_W-1:0]   reg_wdata_o,
  input  logic [EVT_W-1:0]   en_i,
  input  logic [EVT_W-1:0]   st_i,
  output logic               rdy_n_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] IN_ADDR = ADDR_W'(NUM_OUT);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(NUM_OUT + 1);
  localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(NUM_OUT + 2);

  seq_state_e        state_q;
  logic              stb_prev_q;
  logic [ADDR_W-1:0] acc_addr_q;
  logic              acc_rd_q;
  logic [DATA_W-1:0] acc_wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic              start, busy, done;
  logic [NUM_OUT-1:0] ch_hit;
  logic              is_out, is_in, is_en, is_st;
  logic [DATA_W-1:0] rd_val;

  assign start = (state_q == SEQ_IDLE) && stb_prev_q && !stb_n_s && !ce_n_s;
  assign busy  = (state_q == SEQ_BUSY);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
    assign ch_hit[i]    = (acc_addr_q == ADDR_W'(i));
    assign out_valid[i] = busy && !acc_rd_q && ch_hit[i];
  end

  assign is_out = |ch_hit;
  assign is_in  = (acc_addr_q == IN_ADDR);
  assign is_en  = (acc_addr_q == EN_ADDR);
  assign is_st  = (acc_addr_q == ST_ADDR);

  assign out_data = acc_wdata_q;
  assign in_ready = busy && acc_rd_q && is_in;

  always_comb begin
    if (is_out && !acc_rd_q)     done = |(out_valid & out_ready);
    else if (is_in && acc_rd_q)  done = in_valid;
    else                         done = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    if (acc_rd_q) begin
      if (is_in)      rd_val = in_data;
      else if (is_en) rd_val = DATA_W'(en_i);
      else if (is_st) rd_val = DATA_W'(st_i);
    end
  end

  assign en_we_o     = busy && !acc_rd_q && is_en;
  assign st_we_o     = busy && !acc_rd_q && is_st;
  assign reg_wdata_o = acc_wdata_q[EVT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      stb_prev_q  <= 1'b1;
      acc_addr_q  <= '0;
      acc_rd_q    <= 1'b0;
      acc_wdata_q <= '0;
      rdata_q     <= '0;
    end else begin
      stb_prev_q <= stb_n_s;
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          acc_addr_q  <= addr_i;
          acc_rd_q    <= rw_s;
          acc_wdata_q <= wdata_i;
          state_q     <= SEQ_BUSY;
        end
        SEQ_BUSY: if (done) begin
          rdata_q <= rd_val;
          state_q <= SEQ_DONE;
        end
        SEQ_DONE: if (stb_n_s) state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rdy_n_o = (state_q != SEQ_DONE);
  assign rdata_o = rdata_q;

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |=> ((out_valid == $past(out_valid)) && $stable(out_data)));
  assert_one_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));
  assert_single_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && (|out_valid)));
  assert_out_then_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & out_ready)) |=> !rdy_n_o);
  assert_in_then_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> (!rdy_n_o && !in_ready));
endmodule

// File: rtl/hbus_reg_port.sv
module hbus_reg_port #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 3,
  parameter int EVT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_ce_n,
  input  logic               host_rw,
  input  logic               host_stb_n,
  input  logic [ADDR_W-1:0]  host_addr,
  inout  wire  [DATA_W-1:0]  host_data,
  output logic               host_rdy_n,
  output logic               host_irq,
  output logic [NUM_OUT-1:0] out_valid,
  output logic [DATA_W-1:0]  out_data,
  input  logic [NUM_OUT-1:0] out_ready,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  input  logic [EVT_W-1:0]   irq_evt
);
  localparam int CTL_W = 3;

  logic [CTL_W-1:0]  ctl_s;
  logic              en_we, st_we, rdy_n_int;
  logic [EVT_W-1:0]  reg_wdata, en_v, st_v;
  logic [DATA_W-1:0] rdata;
  logic              bus_drive;

  hbus_sync #(.WIDTH(CTL_W), .RST_VAL('1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({host_ce_n, host_rw, host_stb_n}),
    .sync_o  (ctl_s)
  );

  hbus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT), .EVT_W(EVT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n_s      (ctl_s[2]),
    .rw_s        (ctl_s[1]),
    .stb_n_s     (ctl_s[0]),
    .addr_i      (host_addr),
    .wdata_i     (host_data),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .en_we_o     (en_we),
    .st_we_o     (st_we),
    .reg_wdata_o (reg_wdata),
    .en_i        (en_v),
    .st_i        (st_v),
    .rdy_n_o     (rdy_n_int),
    .rdata_o     (rdata)
  );

  hbus_irq #(.EVT_W(EVT_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (irq_evt),
    .en_we_i (en_we),
    .st_we_i (st_we),
    .wdata_i (reg_wdata),
    .en_o    (en_v),
    .st_o    (st_v),
    .irq_o   (host_irq)
  );

  assign bus_drive  = !host_ce_n && host_rw && !host_stb_n;
  assign host_data  = bus_drive ? rdata : {DATA_W{1'bz}};
  assign host_rdy_n = host_ce_n ? 1'bz : rdy_n_int;
endmodule

// File: tb/hbus_reg_port_tb_top.sv
module hbus_reg_port_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, rw = 1'b1, stb_n = 1'b1;
  logic [2:0] addr = '0;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_dout = '0;
  wire  [7:0] bus_w;
  wire        rdy_w;
  logic       irq;
  logic [2:0] out_valid, out_ready = '0;
  logic [7:0] out_data, in_data = '0;
  logic       in_valid = 1'b0, in_ready;
  logic [3:0] evt = '0;

  assign bus_w = tb_drv ? tb_dout : 8'bz;
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup pu_d (bus_w[i]);
  end
  pullup pu_r (rdy_w);

  hbus_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_ce_n(ce_n), .host_rw(rw), .host_stb_n(stb_n),
    .host_addr(addr), .host_data(bus_w), .host_rdy_n(rdy_w), .host_irq(irq),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .irq_evt(evt)
  );

  int checks = 0, errors = 0;
  bit hold_ready = 0;
  int got_ch[$];
  logic [7:0] got_d[$];
  logic [7:0] in_q[$];
  logic [3:0] m_en = '0, m_st = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_irq(input logic [3:0] st, input logic [3:0] en);
    return |(st & en);
  endfunction

  // engine model: decide handshakes at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = hold_ready ? 3'b000 : 3'($urandom % 8);
      if (|(out_valid & out_ready)) begin
        for (int i = 0; i < 3; i++) if (out_valid[i]) got_ch.push_back(i);
        got_d.push_back(out_data);
      end
      in_valid = (in_q.size() > 0) && ($urandom % 2 == 1);
      if (in_q.size() > 0) in_data = in_q[0];
      if (in_valid && in_ready) void'(in_q.pop_front());
    end
  end

  task automatic wait_rdy(input logic lvl, input string req);
    int n = 0;
    @(negedge clk);
    while (rdy_w !== lvl && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) chk(0, req, rdy_w, lvl);
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    ce_n = 0; rw = 0; addr = a; tb_dout = d; tb_drv = 1;
    repeat (3) @(negedge clk);
    stb_n = 0;
    wait_rdy(1'b0, "R4");
    stb_n = 1;
    wait_rdy(1'b1, "R4");
    ce_n = 1; tb_drv = 0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    ce_n = 0; rw = 1; addr = a;
    repeat (3) @(negedge clk);
    stb_n = 0;
    wait_rdy(1'b0, "R4");
    d = bus_w;
    stb_n = 1;
    wait_rdy(1'b1, "R4");
    ce_n = 1;
  endtask

  task automatic pulse_evt(input logic [3:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
    m_st = m_st | e;
  endtask

  task automatic do_op(input logic [2:0] a, input bit rd, input logic [7:0] d);
    logic [7:0] r;
    got_ch.delete(); got_d.delete();
    if (rd) begin
      if (a == 3) in_q.push_back(d);
      host_read(a, r);
      case (a)
        3'd3: chk(r == d, "R5", r, d);
        3'd4: chk(r == {4'b0, m_en}, "R6", r, {4'b0, m_en});
        3'd5: chk(r == {4'b0, m_st}, "R7", r, {4'b0, m_st});
        3'd6, 3'd7: chk(r == 8'h00, "R9", r, 0);
        default: chk(r == 8'h00, "R2", r, 0);
      endcase
      chk(got_ch.size() == 0, "R2", got_ch.size(), 0);
    end else begin
      host_write(a, d);
      if (a < 3) begin
        chk(got_ch.size() == 1, "R3", got_ch.size(), 1);
        if (got_ch.size() == 1) begin
          chk(got_ch[0] == a, "R3", got_ch[0], a);
          chk(got_d[0] == d, "R3", got_d[0], d);
        end
      end else begin
        chk(got_ch.size() == 0, "R9", got_ch.size(), 0);
        if (a == 4) m_en = d[3:0];
        if (a == 5) m_st = m_st & ~d[3:0];
      end
    end
    @(negedge clk);
    chk(irq == exp_irq(m_st, m_en), "R8", irq, exp_irq(m_st, m_en));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(out_valid == 0 && !in_ready, "R10", {out_valid, in_ready}, 0);
    chk(irq == 0, "R10", irq, 0);
    ce_n = 0; @(negedge clk);
    chk(rdy_w === 1'b1, "R10", rdy_w, 1);
    ce_n = 1;
    host_read(3'd4, r); chk(r == 0, "R10", r, 0);
    host_read(3'd5, r); chk(r == 0, "R10", r, 0);

    // R2 strobe while deselected: no access
    got_ch.delete();
    rw = 0; addr = 3'd1; tb_dout = 8'hA5; tb_drv = 1;
    repeat (3) @(negedge clk); stb_n = 0;
    repeat (10) @(negedge clk);
    chk(got_ch.size() == 0, "R2", got_ch.size(), 0);
    stb_n = 1; repeat (5) @(negedge clk); tb_drv = 0;

    // R4 back-pressure
    hold_ready = 1;
    got_ch.delete(); got_d.delete();
    ce_n = 0; rw = 0; addr = 3'd2; tb_dout = 8'h3C; tb_drv = 1;
    repeat (3) @(negedge clk); stb_n = 0;
    repeat (30) @(negedge clk);
    chk(rdy_w === 1'b1, "R4", rdy_w, 1);
    chk(out_valid == 3'b100 && out_data == 8'h3C, "R3", {out_valid, out_data}, 11'h43C);
    hold_ready = 0;
    wait_rdy(1'b0, "R4");
    chk(got_ch.size() == 1 && got_d[0] == 8'h3C, "R3", got_ch.size(), 1);
    stb_n = 1; wait_rdy(1'b1, "R4");
    ce_n = 1; tb_drv = 0;

    // R1 bus and ready tristate
    in_q.push_back(8'h5A);
    ce_n = 0; rw = 1; addr = 3'd3;
    repeat (3) @(negedge clk); stb_n = 0;
    wait_rdy(1'b0, "R5");
    chk(bus_w == 8'h5A, "R5", bus_w, 8'h5A);
    ce_n = 1; @(negedge clk);
    chk(rdy_w === 1'b1, "R1", rdy_w, 1);
    chk(bus_w == 8'hFF, "R1", bus_w, 8'hFF);
    ce_n = 0; @(negedge clk);
    chk(rdy_w === 1'b0 && bus_w == 8'h5A, "R1", bus_w, 8'h5A);
    stb_n = 1; @(negedge clk);
    chk(bus_w == 8'hFF, "R1", bus_w, 8'hFF);
    wait_rdy(1'b1, "R4"); ce_n = 1;

    // R6 R7 R8 interrupt path directed
    do_op(3'd4, 0, 8'hF5);
    do_op(3'd4, 1, 8'h00);
    pulse_evt(4'b0010);
    @(negedge clk); chk(irq == 0, "R8", irq, 0);
    pulse_evt(4'b0001);
    @(negedge clk); chk(irq == 1, "R8", irq, 1);
    do_op(3'd5, 1, 8'h00);
    do_op(3'd5, 0, 8'h01);
    do_op(3'd5, 1, 8'h00);
    // R9 unused addresses
    do_op(3'd6, 0, 8'hFF);
    do_op(3'd7, 1, 8'h00);
    do_op(3'd4, 1, 8'h00);

    // random mix
    for (int k = 0; k < 60; k++) begin
      if ($urandom % 4 == 0) pulse_evt(4'($urandom));
      do_op(3'($urandom), 1'($urandom), 8'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule